// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating

The block sends bytes over an asynchronous serial line. Bytes are written through a valid/ready interface into a transmit queue. Each byte then goes out as one character: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The line stays high while nothing is sent. Bit timing comes from a baud tick enable, and every bit lasts a fixed number of ticks.

When automatic clear-to-send gating is enabled, an active-low clear-to-send input is synchronised and decides whether characters may start. The transmitter checks this input once per character, at the middle of the stop bit. A character that has started always finishes. Only the following character is held back, and the transmitter stays idle until the input goes low again. When gating is disabled, the input is ignored.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset, tx_o is high (idle), busy_o is low and wr_ready_o is high.
- R2: Each character is a start bit at 0, then data bits 0 to 7 with bit 0 first, then a stop bit at 1. Every bit lasts exactly OVERSAMPLE (16) accepted baud ticks.
- R3: Bytes accepted with wr_valid_i and wr_ready_o both high go out in the order they were written, with no loss and no duplicates.
- R4: The queue holds FIFO_DEPTH (64) bytes. wr_ready_o is low while the queue is full, and a byte offered while it is low is not taken.
- R5: With gating enabled and cts_ni low, queued bytes go out back to back: the next start bit begins on the tick that ends the previous stop bit.
- R6: With gating enabled, if cts_ni goes high before the middle of a character's stop bit, that character still finishes and the next queued character does not start.
- R7: With gating enabled, once cts_ni returns low, the held bytes are sent.
- R8: A cts_ni rise after the middle of the stop bit does not stop the following character. It takes effect only at that character's own stop-bit midpoint.
- R9: With gating disabled, cts_ni has no effect, and queued bytes go out back to back even while cts_ni is high.
- R10: busy_o is high for the whole of every character, and low when no character is on the line.
- R11: With gating enabled and cts_ni high, the idle transmitter starts no character even when bytes are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write request for one byte |
| wr_data_i | input | 8 | Byte to queue |
| wr_ready_o | output | 1 | Queue can accept a byte |
| baud_tick_i | input | 1 | Baud tick enable, one pulse per sub-bit period |
| cts_ni | input | 1 | Clear to send, active low, asynchronous |
| auto_cts_en_i | input | 1 | Enables gating by cts_ni |
| tx_o | output | 1 | Serial output line |
| busy_o | output | 1 | A character is being sent |

## Verification
The bench uses the default parameters: 8 data bits, a 64-entry queue, 16 ticks per bit and a two-stage synchroniser. It pulses the tick every second clock, so one character takes 320 clocks. This makes it cheap to fill the queue to its full depth and to place clear-to-send edges at a chosen data bit or just past the stop-bit midpoint. A monitor in the bench decodes the line tick by tick. It compares each byte and each frame bit against the bench's own model, and it records whether each character follows the previous one with no gap.

// File: rtl/uart_cts_tx_pkg.sv
package uart_cts_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/cts_tx_fifo.sv
module cts_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o
);
  // DEPTH must be a power of two; pointers wrap naturally
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [PTR_W:0]   count_q;

  assign full_o  = (count_q == (PTR_W+1)'(DEPTH));
  assign empty_o = (count_q == '0);
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= (PTR_W+1)'(DEPTH));
  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/cts_tx_sync.sv
module cts_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  logic [STAGES-1:0] sync_q;

  // resets to 1: not clear to send
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], in_i};
  end

  assign out_o = sync_q[STAGES-1];
endmodule

// File: rtl/cts_tx_shifter.sv
module cts_tx_shifter
  import uart_cts_tx_pkg::*;
#(
  parameter int W          = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         allow_i,
  input  logic         have_data_i,
  input  logic [W-1:0] data_i,
  output logic         load_o,
  output logic         tx_o,
  output logic         busy_o
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] TOP  = IDX_W'(W - 1);

  tx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [W-1:0]     shreg_q;
  logic             tx_q;
  logic             go_q;   // stop-bit midpoint decision
  logic             bit_end;

  assign bit_end = tick_i && (cnt_q == LAST);
  assign load_o  = (state_q == ST_IDLE && have_data_i && allow_i) ||
                   (state_q == ST_STOP && bit_end && have_data_i && go_q);
  assign tx_o    = tx_q;
  assign busy_o  = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      tx_q    <= 1'b1;
      go_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (load_o) begin
            state_q <= ST_START;
            shreg_q <= data_i;
            cnt_q   <= '0;
            tx_q    <= 1'b0;
          end
        end
        ST_START: begin
          if (bit_end) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= ST_DATA;
            tx_q    <= shreg_q[0];
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            if (idx_q == TOP) begin
              state_q <= ST_STOP;
              tx_q    <= 1'b1;
            end else begin
              idx_q   <= idx_q + 1'b1;
              shreg_q <= shreg_q >> 1;
              tx_q    <= shreg_q[1];
            end
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (tick_i && cnt_q == MID) go_q <= allow_i;
          if (bit_end) begin
            cnt_q <= '0;
            if (load_o) begin
              state_q <= ST_START;
              shreg_q <= data_i;
              tx_q    <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> tx_q);
  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_START |-> !tx_q);
  a_r2_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && state_q != ST_IDLE) |=> $stable(cnt_q));
  a_r11_stay_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !allow_i) |=> state_q == ST_IDLE);
  a_r5_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && bit_end && go_q && have_data_i) |=> state_q == ST_START);
  a_r6_blocked_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && bit_end && !go_q) |=> state_q == ST_IDLE);
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx #(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 64,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  input  logic              baud_tick_i,
  input  logic              cts_ni,
  input  logic              auto_cts_en_i,
  output logic              tx_o,
  output logic              busy_o
);
  logic              full, empty, push, pop, cts_n_sync, allow;
  logic [DATA_W-1:0] head;

  assign wr_ready_o = !full;
  assign push       = wr_valid_i && !full;
  assign allow      = !auto_cts_en_i || !cts_n_sync;

  cts_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (wr_data_i),
    .full_o  (full),
    .pop_i   (pop),
    .rdata_o (head),
    .empty_o (empty)
  );

  cts_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (cts_ni),
    .out_o  (cts_n_sync)
  );

  cts_tx_shifter #(.W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (baud_tick_i),
    .allow_i     (allow),
    .have_data_i (!empty),
    .data_i      (head),
    .load_o      (pop),
    .tx_o        (tx_o),
    .busy_o      (busy_o)
  );
endmodule

// File: tb/uart_cts_tx_test.sv
module uart_cts_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int OVS        = 16;
  localparam int DEPTH      = 64;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_valid = 1'b0, tick = 1'b0, cts_n = 1'b1, auto_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, tx, busy;

  int errors = 0, checks = 0;
  int div = 0;

  uart_cts_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_ready_o(wr_ready), .baud_tick_i(tick), .cts_ni(cts_n),
    .auto_cts_en_i(auto_en), .tx_o(tx), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      div  <= 0;
      tick <= 1'b0;
    end else begin
      div  <= (div == TICK_DIV-1) ? 0 : div + 1;
      tick <= (div == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit frame_bit(input logic [7:0] b, input int pos);
    if (pos == 0) return 1'b0;
    if (pos == 9) return 1'b1;
    return b[pos-1];
  endfunction

  function automatic int b2b_expected(input int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  // line monitor, tick-accurate
  logic [7:0] exp_q[$];
  int mon_st = 0, mon_cnt = 0, mon_bit = 0;
  int rx_count = 0, b2b_count = 0, mid_stop_cnt = 0;
  logic [7:0] mon_byte = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mon_st == 0) begin
        if (!tx) begin mon_st = 1; mon_cnt = 0; end
      end else if (tick) begin
        mon_cnt++;
        if (mon_cnt == OVS/2) begin
          chk(busy == 1'b1, "R10 busy during frame", busy, 1);
          if (mon_st == 1) chk(tx == frame_bit(8'h00, 0), "R2 start bit", tx, 0);
          else if (mon_st == 2) mon_byte[mon_bit] = tx;
          else begin
            chk(tx == frame_bit(8'h00, 9), "R2 stop bit", tx, 1);
            mid_stop_cnt++;
          end
        end
        if (mon_cnt == OVS) begin
          mon_cnt = 0;
          if (mon_st == 1) begin
            mon_st = 2; mon_bit = 0;
          end else if (mon_st == 2) begin
            if (mon_bit == 7) mon_st = 3; else mon_bit++;
          end else begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected byte", mon_byte, -1);
            else begin
              logic [7:0] e;
              e = exp_q.pop_front();
              chk(mon_byte == e, "R2 R3 byte value", mon_byte, e);
            end
            rx_count++;
            if (!tx) begin b2b_count++; mon_st = 1; end
            else mon_st = 0;
          end
        end
      end
    end
  end

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = b;
    exp_q.push_back(b);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_q.size() != 0 || mon_st != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int c0, b0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx == 1'b1, "R1 tx idle", tx, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(wr_ready == 1'b1, "R1 ready", wr_ready, 1);

    // R9: gating off, cts high ignored
    auto_en = 1'b0; cts_n = 1'b1;
    c0 = rx_count; b0 = b2b_count;
    write_byte(8'hA5); write_byte(8'h01); write_byte(8'h80); write_byte(8'h3C);
    wait_idle();
    chk(rx_count - c0 == 4, "R9 count", rx_count - c0, 4);
    chk(b2b_count - b0 == b2b_expected(4), "R9 back to back", b2b_count - b0, 3);

    // R11: gating on, cts high, nothing starts
    auto_en = 1'b1; cts_n = 1'b1;
    c0 = rx_count; b0 = b2b_count;
    write_byte(8'h11); write_byte(8'h22); write_byte(8'h33);
    repeat (2000) @(negedge clk);
    chk(rx_count == c0 && mon_st == 0, "R11 held count", rx_count - c0, 0);
    chk(tx == 1'b1, "R11 line high", tx, 1);
    chk(busy == 1'b0, "R10 busy idle", busy, 0);

    // R7/R5: release, back to back
    cts_n = 1'b0;
    wait_idle();
    chk(rx_count - c0 == 3, "R7 resume count", rx_count - c0, 3);
    chk(b2b_count - b0 == b2b_expected(3), "R5 back to back", b2b_count - b0, 2);

    // R6: raise before midpoint, during data bit 3
    c0 = rx_count;
    write_byte(8'hC3); write_byte(8'h5A); write_byte(8'hF0);
    while (!(mon_st == 2 && mon_bit == 3)) @(negedge clk);
    cts_n = 1'b1;
    repeat (1500) @(negedge clk);
    chk(rx_count - c0 == 1, "R6 current completes only", rx_count - c0, 1);
    chk(tx == 1'b1 && busy == 1'b0, "R6 line idle", {tx, busy}, 2);
    cts_n = 1'b0;
    wait_idle();
    chk(rx_count - c0 == 3, "R7 resume after hold", rx_count - c0, 3);

    // R8: raise just after stop midpoint
    c0 = rx_count;
    write_byte(8'h0F); write_byte(8'h96); write_byte(8'h69);
    b0 = mid_stop_cnt;
    while (mid_stop_cnt == b0) @(negedge clk);
    repeat (4) @(negedge clk);
    cts_n = 1'b1;
    repeat (1500) @(negedge clk);
    chk(rx_count - c0 == 2, "R8 next still sent", rx_count - c0, 2);
    chk(exp_q.size() == 1, "R8 third held", exp_q.size(), 1);
    cts_n = 1'b0;
    wait_idle();

    // R4: fill queue
    cts_n = 1'b1;
    repeat (8) @(negedge clk);
    c0 = rx_count;
    for (int i = 0; i < DEPTH; i++) write_byte(8'(i * 37 + 5));
    @(negedge clk);
    chk(wr_ready == 1'b0, "R4 ready low when full", wr_ready, 0);
    wr_valid = 1'b1; wr_data = 8'hEE;   // offered while not ready: must be dropped
    repeat (3) @(negedge clk);
    wr_valid = 1'b0;
    chk(rx_count == c0, "R11 full queue held", rx_count - c0, 0);
    cts_n = 1'b0;
    wait_idle();
    chk(rx_count - c0 == DEPTH, "R4 all sent once", rx_count - c0, DEPTH);

    // random mix
    for (int i = 0; i < 120; i++) begin
      if (exp_q.size() >= DEPTH - 4) cts_n = 1'b0;
      write_byte(8'($urandom));
      if ($urandom_range(0, 7) == 0) cts_n = ~cts_n;
      if ($urandom_range(0, 15) == 0) auto_en = ~auto_en;
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(0, 400)) @(negedge clk);
    end
    cts_n = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);
    chk(tx == 1'b1 && busy == 1'b0, "R10 idle at end", {tx, busy}, 2);
    finish_run();
  end
endmodule